// File: doc/BRIEF.md
# Log-Step Parallel Prefix Adder

This block computes the inclusive running sum across a vector of lanes. It takes one vector of signed lane values with a valid strobe. It returns, for every lane, the wrapping sum of that lane and all lanes with lower index, marked by a done strobe. With the default parameters there are 32 lanes of 32 bits each.

The sum is not formed by a serial carry from lane to lane. The engine runs log2(LANES) combining steps. In each step the reach doubles: 1, 2, 4, 8 and then 16 lanes. A lane adds the value of the lane that lies the current reach below it, but only when its own index is at least that reach. Otherwise the lane passes its value through unchanged.

A build-time parameter selects one of two forms. The iterative form holds one vector register and one combining stage, and applies that stage once per cycle. The pipelined form has one registered stage per step and accepts a new vector on every cycle.

Top module: `prefix_scan_engine`

## Requirements
- R1: When done is high, output lane i (bits i*WIDTH+WIDTH-1 down to i*WIDTH on both buses) equals the sum of input lanes 0..i of the accepted vector. A single nonzero input at lane k therefore appears unchanged in every lane at or above k, and lanes below k read zero.
- R2: Output lane 0 always equals input lane 0 of the same vector.
- R3: All additions wrap modulo 2^WIDTH with no saturation. For example, 0x7FFFFFFF + 0x7FFFFFFF gives 0xFFFFFFFE.
- R4: In the iterative form (PIPELINED=0), a vector accepted on a rising edge produces out_done high for exactly one cycle, beginning at the fifth rising edge after the accepting edge.
- R5: In the iterative form, in_valid sampled on any of the five edges that follow an accepting edge is ignored. It does not alter the result and it does not cause an extra done pulse.
- R6: In the iterative form, in_valid sampled on the edge right after the one that raised done is accepted. That vector's result follows five edges later.
- R7: In the iterative form, while the engine is idle and no vector is accepted, out_data holds the last result and out_done stays low.
- R8: In the pipelined form (PIPELINED=1), a vector is accepted on every edge where in_valid is high. Each result appears in input order with out_done high exactly five edges after its accepting edge.
- R9: After reset, out_done is low and out_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector is present this cycle |
| in_data | input | LANES*WIDTH | Input lanes, lane i at bits i*WIDTH +: WIDTH |
| out_done | output | 1 | out_data holds a completed result this cycle |
| out_data | output | LANES*WIDTH | Inclusive prefix sums, lane i at bits i*WIDTH +: WIDTH |

## Verification
Several internal faults show up as soon as the next done pulse, because they change the lanes in distinct ways. A wrong reach or a misplaced lane guard corrupts the lanes above the first affected distance. A wrong step counter changes when done rises, or repeats or skips a stage, which garbles every lane above 1. A busy flag that clears early lets a second start overwrite the register in the middle of a run. Single-lane impulses at each position and full-scale vectors that wrap expose these faults at the lane and cycle where they first appear, and stream tests check the per-stage alignment of the pipelined form.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Number of doubling steps needed to cover a lane count.
  function automatic int scan_depth(input int lanes);
    return $clog2(lanes);
  endfunction

  // Width of a counter that indexes those steps.
  function automatic int step_bits(input int lanes);
    return ($clog2(lanes) > 1) ? $clog2($clog2(lanes)) : 1;
  endfunction

  // Lane reach used by a given step: 1, 2, 4, ...
  function automatic int step_distance(input int step);
    return 1 << step;
  endfunction

endpackage

// File: rtl/scan_stage.sv
module scan_stage
  import scan_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int WIDTH  = 32,
  parameter int STEP_W = step_bits(LANES)
) (
  input  logic [LANES-1:0][WIDTH-1:0] vec_i,
  input  logic [STEP_W-1:0]           step_i,
  output logic [LANES-1:0][WIDTH-1:0] vec_o,
  output logic [LANES-1:0]            add_en_o
);

  localparam int STEPS = scan_depth(LANES);

  function automatic logic [WIDTH-1:0] wrap_add(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b);
    return a + b;
  endfunction

  logic step_ok;
  assign step_ok = (int'(step_i) < STEPS);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STEPS-1:0][WIDTH-1:0] nbr;
    logic [STEPS-1:0]            guard;

    for (genvar d = 0; d < STEPS; d++) begin : g_dist
      localparam int DIST = step_distance(d);
      if (l >= DIST) begin : g_reach
        assign nbr[d]   = vec_i[l-DIST];
        assign guard[d] = 1'b1;
      end else begin : g_low
        assign nbr[d]   = '0;
        assign guard[d] = 1'b0;
      end
    end

    assign add_en_o[l] = step_ok && guard[step_i];
    assign vec_o[l]    = add_en_o[l] ? wrap_add(vec_i[l], nbr[step_i]) : vec_i[l];
  end

endmodule

// File: rtl/scan_iter_ctrl.sv
module scan_iter_ctrl #(
  parameter int STEPS  = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o,
  output logic              last_o,
  output logic              done_o
);

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;

  assign accept_o = start_i & ~busy_q;
  assign last_o   = busy_q && (step_q == STEP_W'(STEPS-1));
  assign busy_o   = busy_q;
  assign step_o   = step_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/prefix_scan_engine.sv
module prefix_scan_engine
  import scan_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int WIDTH     = 32,
  parameter bit PIPELINED = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [LANES*WIDTH-1:0] in_data,
  output logic                   out_done,
  output logic [LANES*WIDTH-1:0] out_data
);

  localparam int STEPS  = scan_depth(LANES);
  localparam int STEP_W = step_bits(LANES);

  logic [LANES-1:0][WIDTH-1:0] in_vec;
  logic [LANES-1:0][WIDTH-1:0] out_vec;
  assign in_vec   = in_data;
  assign out_data = out_vec;

  // Internal events made visible for the bound checker.
  logic              accept_w;
  logic              busy_w;
  logic              last_w;
  logic [STEP_W-1:0] step_w;
  logic [WIDTH-1:0]  stg_in0;
  logic [WIDTH-1:0]  stg_out0;

  if (!PIPELINED) begin : g_iter
    logic [LANES-1:0][WIDTH-1:0] acc_q;
    logic [LANES-1:0][WIDTH-1:0] acc_nxt;
    logic [LANES-1:0]            add_en;
    logic                        done_w;

    scan_iter_ctrl #(.STEPS(STEPS), .STEP_W(STEP_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (in_valid),
      .accept_o (accept_w),
      .busy_o   (busy_w),
      .step_o   (step_w),
      .last_o   (last_w),
      .done_o   (done_w)
    );

    scan_stage #(.LANES(LANES), .WIDTH(WIDTH), .STEP_W(STEP_W)) u_stage (
      .vec_i    (acc_q),
      .step_i   (step_w),
      .vec_o    (acc_nxt),
      .add_en_o (add_en)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
      end else if (accept_w) begin
        acc_q <= in_vec;
      end else if (busy_w) begin
        acc_q <= acc_nxt;
      end
    end

    assign out_vec  = acc_q;
    assign out_done = done_w;
    assign stg_in0  = acc_q[0];
    assign stg_out0 = acc_nxt[0];
  end else begin : g_pipe
    logic [STEPS:0][LANES-1:0][WIDTH-1:0]   pipe_q;
    logic [STEPS-1:0][LANES-1:0][WIDTH-1:0] stg_o;
    logic [STEPS-1:0][LANES-1:0]            add_en;
    logic [STEPS:0]                         vld_q;

    for (genvar s = 0; s < STEPS; s++) begin : g_stage
      scan_stage #(.LANES(LANES), .WIDTH(WIDTH), .STEP_W(STEP_W)) u_stage (
        .vec_i    (pipe_q[s]),
        .step_i   (STEP_W'(s)),
        .vec_o    (stg_o[s]),
        .add_en_o (add_en[s])
      );
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= '0;
        pipe_q <= '0;
      end else begin
        vld_q     <= {vld_q[STEPS-1:0], in_valid};
        pipe_q[0] <= in_vec;
        for (int s = 0; s < STEPS; s++) begin
          pipe_q[s+1] <= stg_o[s];
        end
      end
    end

    assign out_vec  = pipe_q[STEPS];
    assign out_done = vld_q[STEPS];
    assign accept_w = in_valid;
    assign busy_w   = 1'b0;
    assign last_w   = 1'b0;
    assign step_w   = '0;
    assign stg_in0  = pipe_q[0][0];
    assign stg_out0 = stg_o[0][0];
  end

endmodule

// File: rtl/prefix_scan_chk.sv
module prefix_scan_chk
  import scan_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int WIDTH     = 32,
  parameter bit PIPELINED = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       out_done,
  input logic [LANES*WIDTH-1:0]     out_data,
  input logic                       accept_w,
  input logic                       busy_w,
  input logic                       last_w,
  input logic [step_bits(LANES)-1:0] step_w,
  input logic [WIDTH-1:0]           stg_in0,
  input logic [WIDTH-1:0]           stg_out0
);

  localparam int STEP_W = step_bits(LANES);

  AST_LANE0_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    stg_out0 == stg_in0); // R2

  if (!PIPELINED) begin : g_iter_props
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done); // R4

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> $past(last_w)); // R4

    AST_ACCEPT_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      accept_w |=> (busy_w && step_w == '0)); // R4

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_w && !last_w) |=> (busy_w && step_w == STEP_W'($past(step_w) + 1'b1))); // R5

    AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_w && !accept_w) |=> ($stable(out_data) && !out_done)); // R7

    AST_START_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_done && in_valid) |-> accept_w); // R6
  end

endmodule

bind prefix_scan_engine prefix_scan_chk #(
  .LANES(LANES), .WIDTH(WIDTH), .PIPELINED(PIPELINED)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_done (out_done),
  .out_data (out_data),
  .accept_w (accept_w),
  .busy_w   (busy_w),
  .last_w   (last_w),
  .step_w   (step_w),
  .stg_in0  (stg_in0),
  .stg_out0 (stg_out0)
);

// File: tb/prefix_scan_engine_tb.sv
module prefix_scan_engine_tb;

  localparam int LANES = 32;
  localparam int WIDTH = 32;
  typedef logic [LANES-1:0][WIDTH-1:0] vec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic i_valid = 1'b0;
  vec_t i_data  = '0;
  logic i_done;
  vec_t i_out;

  logic p_valid = 1'b0;
  vec_t p_data  = '0;
  logic p_done;
  vec_t p_out;

  prefix_scan_engine #(.LANES(LANES), .WIDTH(WIDTH), .PIPELINED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(i_valid), .in_data(i_data),
    .out_done(i_done), .out_data(i_out)
  );

  prefix_scan_engine #(.LANES(LANES), .WIDTH(WIDTH), .PIPELINED(1'b1)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_data(p_data),
    .out_done(p_done), .out_data(p_out)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Serial running sum, wrapping at the lane width.
  function automatic vec_t ref_scan(input vec_t v);
    vec_t r;
    logic [WIDTH-1:0] run = '0;
    for (int i = 0; i < LANES; i++) begin
      run  = run + v[i];
      r[i] = run;
    end
    return r;
  endfunction

  task automatic chk_vec(input string req, input vec_t got, input vec_t exp);
    int bad = -1;
    for (int i = LANES - 1; i >= 0; i--) if (got[i] !== exp[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "vector", got[0], exp[0]);
    else chk(1'b0, req, $sformatf("lane %0d", bad), got[bad], exp[bad]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One iterative run with timing, result and lane-0 checks.
  task automatic iter_run(input vec_t v, input string req);
    vec_t exp = ref_scan(v);
    bit early = 1'b0;
    i_valid = 1'b1; i_data = v;
    tick();                         // after accepting edge
    i_valid = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      tick();
      if (i_done) early = 1'b1;
    end
    chk(!early, "R4", "done before fifth edge", WIDTH'(early), '0);
    tick();                         // after fifth edge
    chk(i_done == 1'b1, "R4", "done at fifth edge", WIDTH'(i_done), 1);
    chk_vec(req, i_out, exp);
    chk(i_out[0] == v[0], "R2", "lane 0", i_out[0], v[0]);
    tick();
    chk(i_done == 1'b0, "R4", "done one cycle", WIDTH'(i_done), 0);
  endtask

  task automatic main_seq();
    vec_t a, b, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(i_done == 1'b0 && p_done == 1'b0, "R9", "done after reset", WIDTH'({i_done, p_done}), 0);
    chk(i_out == '0 && p_out == '0, "R9", "data after reset", i_out[0] | p_out[0], 0);

    for (int i = 0; i < LANES; i++) v[i] = 1;
    iter_run(v, "R1");
    for (int i = 0; i < LANES; i++) v[i] = WIDTH'(i * 3 + 7);
    iter_run(v, "R1");
    for (int k = 0; k < LANES; k++) begin
      v = '0;
      v[k] = WIDTH'(32'h1234_0000 + k);
      iter_run(v, "R1");
    end
    for (int i = 0; i < LANES; i++) v[i] = '1;
    iter_run(v, "R3");
    for (int i = 0; i < LANES; i++) v[i] = 32'h7FFF_FFFF;
    iter_run(v, "R3");
    chk(i_out[1] == 32'hFFFF_FFFE, "R3", "lane 1 wrap", i_out[1], 32'hFFFF_FFFE);
    for (int r = 0; r < 12; r++) begin
      for (int i = 0; i < LANES; i++) v[i] = $urandom;
      iter_run(v, "R1");
    end

    // Starts while busy are ignored.
    for (int i = 0; i < LANES; i++) begin a[i] = $urandom; b[i] = $urandom; end
    i_valid = 1'b1; i_data = a;
    tick();
    i_data = b;
    repeat (4) tick();
    tick();
    i_valid = 1'b0;
    chk(i_done == 1'b1, "R5", "done with ignored starts", WIDTH'(i_done), 1);
    chk_vec("R5", i_out, ref_scan(a));
    for (int k = 0; k < 6; k++) begin
      tick();
      chk(i_done == 1'b0, "R5", "no extra done", WIDTH'(i_done), 0);
      chk_vec("R7", i_out, ref_scan(a));
    end

    // Start on the done cycle is accepted.
    i_valid = 1'b1; i_data = a;
    tick();
    i_valid = 1'b0;
    repeat (4) tick();
    i_valid = 1'b1; i_data = b;
    tick();
    chk(i_done == 1'b1, "R6", "first done", WIDTH'(i_done), 1);
    chk_vec("R6", i_out, ref_scan(a));
    tick();
    i_valid = 1'b0;
    chk(i_done == 1'b0, "R6", "gap", WIDTH'(i_done), 0);
    repeat (4) tick();
    chk(i_done == 1'b0, "R6", "second run early", WIDTH'(i_done), 0);
    tick();
    chk(i_done == 1'b1, "R6", "second done", WIDTH'(i_done), 1);
    chk_vec("R6", i_out, ref_scan(b));

    // Pipelined stream, one vector per cycle.
    begin
      vec_t exp_q[$];
      int   due_q[$];
      int   got = 0;
      fork
        begin
          for (int n = 0; n < 24; n++) begin
            for (int i = 0; i < LANES; i++) v[i] = (n % 4 == 0) ? 32'h7FFF_FFFF : $urandom;
            p_valid = 1'b1; p_data = v;
            exp_q.push_back(ref_scan(v));
            due_q.push_back(cyc + 1 + 5);
            @(negedge clk);
          end
          p_valid = 1'b0;
        end
        begin
          for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (p_done) begin
              vec_t e = exp_q.pop_front();
              int   d = due_q.pop_front();
              got++;
              chk(cyc == d, "R8", "pipe latency", WIDTH'(cyc), WIDTH'(d));
              chk_vec("R8", p_out, e);
              chk(p_out[0] == e[0], "R2", "pipe lane 0", p_out[0], e[0]);
            end
          end
        end
      join
      chk(got == 24, "R8", "pipe result count", WIDTH'(got), 24);
    end
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R4", "watchdog expired", WIDTH'(cyc), 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule